// File: doc/BRIEF.md
# Serial Mouse Packet Encoder with Byte Queue

This block turns one mouse report (signed X and Y motion plus three button states) into a five-byte packet. It writes the packet into a small circular byte queue. A host drains that queue one byte at a time through a read port with a pop strobe.

The first byte of each packet is a start marker that carries the button states, with a pressed button encoded as 0. The second byte is the X motion and the third is the negated Y motion, each clamped to the range of a signed byte. Two zero bytes close the packet.

Packet bytes enter the queue one per clock. While a packet is still being written, a busy output holds off the next report. A receive-available output tells the host that bytes are waiting.

Top module: `mouse_pkt_queue`

## Requirements
- R1: The start byte is 0x87 with bit 2 cleared when `btn_left` is 1, bit 1 cleared when `btn_mid` is 1, and bit 0 cleared when `btn_right` is 1.
- R2: The second byte is `dx` clamped to -127..+127 and sent as a two's-complement byte. Values above 127 become 0x7F, and values below -127 become 0x81.
- R3: The third byte is `-dy` clamped to -127..+127 and sent as a two's-complement byte. Negating the most negative input does not wrap.
- R4: The fourth and fifth bytes are always 0x00.
- R5: A report is accepted on a rising clock edge where `rpt_valid` is 1 and `busy` is 0. The start byte enters the queue at that edge, and bytes two to five enter at the next four edges. `busy` is 1 for exactly those four cycles. A report presented while `busy` is 1 is ignored.
- R6: The queue holds DEPTH (16) bytes. A byte written while the queue is full is discarded and leaves the queue unchanged. Fullness is judged before any pop in the same cycle.
- R7: When the queue is empty, `rd_data` reads 0x00 and a pop has no effect.
- R8: Bytes leave the queue in the order they entered. `rd_data` shows the oldest byte, and a pop advances the read pointer with wraparound.
- R9: `rx_avail` is set by every byte that enters the queue. After a pop, it stays 1 only while bytes remain.
- R10: After reset, `busy` and `rx_avail` are 0 and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_valid | input | 1 | Report strobe |
| dx | input | MW (10) | Signed X motion |
| dy | input | MW (10) | Signed Y motion |
| btn_left | input | 1 | Left button pressed |
| btn_mid | input | 1 | Middle button pressed |
| btn_right | input | 1 | Right button pressed |
| busy | output | 1 | Packet still being written; reports are ignored |
| rx_avail | output | 1 | Queue holds at least one byte |
| pop | input | 1 | Consume the byte on `rd_data` |
| rd_data | output | 8 | Oldest queued byte, or 0x00 when empty |

## Verification
Byte k of a packet (k = 0..4) is readable k cycles after the accepting edge. Because of this, the driver waits for `busy` to fall before the monitor pops, and every byte is then in place.

`rd_data` and `rx_avail` are combinational views of registered state. They are sampled at the falling edge before each pop, and the pop takes effect at the next rising edge.

The scoreboard applies the clamping, negation and drop-on-full rules itself. It models the rejected report that arrives during `busy` as producing nothing, so any stray byte shows up as a mismatch during the drain.

// File: rtl/mouse_pkt_queue.sv
module mouse_pkt_queue #(
  parameter int MW    = 10,
  parameter int DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rpt_valid,
  input  logic signed [MW-1:0] dx,
  input  logic signed [MW-1:0] dy,
  input  logic                 btn_left,
  input  logic                 btn_mid,
  input  logic                 btn_right,
  output logic                 busy,
  output logic                 rx_avail,
  input  logic                 pop,
  output logic [7:0]           rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  function automatic logic [7:0] clamp8(input logic signed [MW:0] v);
    if (v > 127)       return 8'h7f;
    else if (v < -127) return 8'h81;
    else               return v[7:0];
  endfunction

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic [31:0]   stage;
  logic [2:0]    left;

  logic        accept, push, push_ok, pop_ok, full;
  logic [7:0]  start_byte, push_byte;
  logic signed [MW:0] dx_w, dy_neg;

  assign busy       = (left != 3'd0);
  assign accept     = rpt_valid && !busy;
  assign start_byte = 8'h87 ^ {5'b0, btn_left, btn_mid, btn_right} << 0;
  assign dx_w       = {dx[MW-1], dx};
  assign dy_neg     = -{dy[MW-1], dy};
  assign push       = accept || busy;
  assign push_byte  = accept ? start_byte : stage[31:24];
  assign full       = (count == CW'(DEPTH));
  assign push_ok    = push && !full;
  assign pop_ok     = pop && (count != '0);
  assign rd_data    = (count != '0) ? mem[rptr] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left  <= 3'd0;
      stage <= '0;
    end else if (accept) begin
      left  <= 3'd4;
      stage <= {clamp8(dx_w), clamp8(dy_neg), 16'h0000};
    end else if (busy) begin
      left  <= left - 3'd1;
      stage <= {stage[23:0], 8'h00};
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      rx_avail <= 1'b0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_ok)     rx_avail <= 1'b1;
      else if (pop_ok) rx_avail <= (count != CW'(1));
    end
  end
endmodule

module mouse_pkt_queue_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rpt_valid,
  input logic          busy,
  input logic          rx_avail,
  input logic          pop,
  input logic [7:0]    rd_data,
  input logic          push_ok,
  input logic [CW-1:0] count
);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !busy) |=> busy);
  assert_busy_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !busy) |=> ##3 busy);
  assert_busy_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !busy) |=> ##4 !busy);
  assert_empty_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_avail |-> rd_data == 8'h00);
  assert_avail_after_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> rx_avail);
  assert_avail_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count == CW'(1) && !push_ok) |=> !rx_avail);
endmodule

bind mouse_pkt_queue mouse_pkt_queue_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .busy(busy),
  .rx_avail(rx_avail), .pop(pop), .rd_data(rd_data),
  .push_ok(push_ok), .count(count)
);

// File: tb/mouse_pkt_queue_tb.sv
module mouse_pkt_queue_tb;
  localparam int MW = 10;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0, rpt_valid = 0, pop = 0;
  logic signed [MW-1:0] dx = 0, dy = 0;
  logic bl = 0, bm = 0, br = 0;
  logic busy, rx_avail;
  logic [7:0] rd_data;

  int tests = 0, fails = 0;
  byte unsigned model[$];

  always #10 clk = ~clk;

  mouse_pkt_queue #(.MW(MW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .dx(dx), .dy(dy),
    .btn_left(bl), .btn_mid(bm), .btn_right(br), .busy(busy),
    .rx_avail(rx_avail), .pop(pop), .rd_data(rd_data));

  task automatic check(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic byte unsigned sat(int v);
    if (v > 127) return 8'h7f;
    if (v < -127) return 8'h81;
    return byte'(v);
  endfunction

  function automatic void model_push(byte unsigned b);
    if (model.size() < DEPTH) model.push_back(b);
  endfunction

  task automatic send(int x, int y, bit l, bit m, bit r);
    while (busy) @(negedge clk);
    dx = MW'(x); dy = MW'(y); bl = l; bm = m; br = r;
    rpt_valid = 1;
    @(negedge clk);
    rpt_valid = 0;
    model_push(8'h87 ^ {5'b0, l, m, r});
    model_push(sat(x));
    model_push(sat(-y));
    model_push(8'h00);
    model_push(8'h00);
    while (busy) @(negedge clk);
  endtask

  task automatic monitor_pop(string req);
    byte unsigned exp;
    exp = (model.size() > 0) ? model.pop_front() : 8'h00;
    check({req, " R9 avail"}, rx_avail, 1);
    check(req, rd_data, exp);
    pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  task automatic drain(string req);
    while (model.size() > 0) monitor_pop(req);
    check("R9 avail clear after last pop", rx_avail, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 busy", busy, 0);
    check("R10 rx_avail", rx_avail, 0);
    check("R10 rd_data", rd_data, 0);
    rst_n = 1;
    @(negedge clk);

    // R7 empty read returns zero; pop has no effect
    pop = 1; @(negedge clk); pop = 0;
    check("R7 empty rd_data", rd_data, 0);
    check("R7 empty avail", rx_avail, 0);

    send(0, 0, 0, 0, 0);     drain("R1 R4 idle packet");
    send(3, -4, 1, 0, 0);    drain("R1 left R3 dy neg");
    send(5, 10, 0, 1, 1);    drain("R1 mid+right");
    send(-5, 0, 1, 1, 1);    drain("R1 all pressed R2");
    send(200, -200, 0, 0, 0); drain("R2 R3 positive clamp");
    send(-300, 300, 0, 0, 0); drain("R2 R3 negative clamp");
    send(-127, 127, 0, 0, 0); drain("R2 R3 edge -127/127");
    send(127, -512, 0, 0, 0); drain("R3 most negative dy");

    // R5: busy right after accept, and report during busy ignored
    while (busy) @(negedge clk);
    dx = 10; dy = 0; bl = 0; bm = 0; br = 0; rpt_valid = 1;
    @(negedge clk);
    check("R5 busy after accept", busy, 1);
    dx = 50; bl = 1; // still held high during busy: must be ignored
    @(negedge clk);
    rpt_valid = 0;
    model_push(8'h87); model_push(8'h0a); model_push(8'h00);
    model_push(8'h00); model_push(8'h00);
    check("R5 busy second cycle", busy, 1);
    repeat (2) @(negedge clk);
    check("R5 busy fourth cycle", busy, 1);
    @(negedge clk);
    check("R5 busy released", busy, 0);
    drain("R5 R8 ignored report");

    // R6 overflow: 20 bytes offered, 16 kept; R8 order with wraparound
    send(1, 1, 0, 0, 0);
    send(2, 2, 1, 0, 0);
    send(3, 3, 0, 1, 0);
    send(4, 4, 0, 0, 1);
    check("R6 model full", model.size(), DEPTH);
    drain("R6 R8 full queue drop");
    monitor_pop_empty();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic monitor_pop_empty();
    check("R7 empty after drain", rd_data, 0);
    pop = 1; @(negedge clk); pop = 0;
    check("R7 avail stays low", rx_avail, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule